// File: doc/BRIEF.md
# Clock-Synchronized Charge-Balance Reset Controller

This block is the digital sequencer of a charge-balance voltage-to-frequency converter whose reset interval is timed by an external conversion clock rather than by a timing capacitor. A fast system clock samples two asynchronous inputs: the comparator trip level from the analog integrator and the conversion clock. Once the comparator has tripped, the controller arms. It then requires a falling edge of the conversion clock followed by a rising edge. On that rising edge it closes the reset switch (`switch_en`) for exactly one conversion-clock period and drives an active-low output pulse (`pulse_n`).

The integrator keeps integrating while the controller waits for the qualifying edges, so the trip level may stay high for several periods. The output pulses therefore line up with conversion-clock rising edges, and their average rate tracks the input. A trip level held permanently high, which is the overrange case, yields one reset every two conversion periods and no more.

A pulse shortener, programmed in system-clock cycles through `short_width`, can end the output pulse before the reset interval ends. It never alters the switch timing. All control pins are plain levels. The block carries no data stream, so it has no valid/ready handshake.

Top module: `cb_reset_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `switch_en` is 0 and `pulse_n` is 1. A synchronous reset issued mid-interval returns the outputs to this idle state at the next clock edge.
- R2: While `cmp_trip` stays low, `switch_en` never rises and `pulse_n` stays high, whatever the conversion clock does.
- R3: After `cmp_trip` rises, the reset interval starts only at a rising conversion-clock edge that is preceded by a falling edge seen after arming. If the trip arrives in the high phase, the next rising edge qualifies. If it arrives in the low phase after the falling edge, the second rising edge qualifies.
- R4: `switch_en` rises exactly 3 system-clock cycles after the rising conversion-clock edge that starts the interval, and it stays high for exactly one conversion period, measured in system cycles from rising edge to the next rising edge.
- R5: `pulse_n` is low only while `switch_en` is high. Its falling edge falls in the same system cycle as the rise of `switch_en`.
- R6: With `short_width` = W, where 1 ≤ W < period, `pulse_n` is low for exactly W system cycles. `switch_en` timing is unchanged.
- R7: With `short_width` = 0 (shortener off) or W ≥ the conversion period, `pulse_n` is low for the whole interval, exactly one period.
- R8: A new arm is accepted only after the interval ends. A trip level still high at that point re-arms at once, so with a constant trip, consecutive `switch_en` rises are exactly two conversion periods apart.
- R9: In a closed charge-balance loop, the number of resets over a window follows input/reference × window/period within ±2. Enabling the shortener changes that count by at most 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk | input | 1 | Conversion clock, asynchronous to `clk` |
| cmp_trip | input | 1 | Comparator trip level, asynchronous, high = integrator crossed threshold |
| short_width | input | WIDTH_W | Output pulse width in system cycles, 0 = shortener off |
| switch_en | output | 1 | Reset-switch enable, high for one conversion period |
| pulse_n | output | 1 | Active-low output pulse |

## Verification
A wrong sequencer state shows at the ports within one conversion period. A skipped edge qualification moves the rise of `switch_en` by a whole period relative to the conversion clock. A late exit makes the measured interval longer than one period. A wrong shortener count changes the low time of `pulse_n`, which the bench measures every pulse. A fault in the re-arm path appears within two periods under a held trip as a spacing different from two periods, and over a longer window as a pulse count that no longer balances the modelled integrator charge.

// File: rtl/cb_reset_pkg.sv
package cb_reset_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WAIT_FALL = 2'd1,
    SEQ_WAIT_RISE = 2'd2,
    SEQ_DISCHARGE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cb_edge_detect.sv
module cb_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/cb_sequencer.sv
module cb_sequencer
  import cb_reset_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic active_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:      if (trip_i) state_d = SEQ_WAIT_FALL;
      SEQ_WAIT_FALL: if (fall_i) state_d = SEQ_WAIT_RISE;
      SEQ_WAIT_RISE: if (rise_i) state_d = SEQ_DISCHARGE;
      SEQ_DISCHARGE: if (rise_i) state_d = trip_i ? SEQ_WAIT_FALL : SEQ_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  assign active_o = (state_q == SEQ_DISCHARGE);

  // R3
  discharge_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> ($past(state_q) == SEQ_WAIT_RISE && $past(rise_i)));

  // R4
  discharge_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> $past(rise_i));
endmodule

// File: rtl/cb_pulse_shaper.sv
module cb_pulse_shaper #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_lo_o
);
  localparam logic [WIDTH_W-1:0] CNT_MAX = {WIDTH_W{1'b1}};

  logic [WIDTH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_lo_o = active_i && ((width_i == '0) || (cnt_q < width_i));

  // R6
  no_relengthen_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && $past(active_i) && !$past(pulse_lo_o) && $stable(width_i)) |-> !pulse_lo_o);
endmodule

// File: rtl/cb_reset_ctrl.sv
module cb_reset_ctrl #(
  parameter int WIDTH_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               conv_clk,
  input  logic               cmp_trip,
  input  logic [WIDTH_W-1:0] short_width,
  output logic               switch_en,
  output logic               pulse_n
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw_in, synced;
  logic conv_s, trip_s, conv_rise, conv_fall, active, pulse_lo;

  assign raw_in = {cmp_trip, conv_clk};

  cb_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_in), .sync_o(synced)
  );

  assign conv_s = synced[0];
  assign trip_s = synced[1];

  cb_edge_detect u_edge (
    .clk(clk), .rst(rst), .level_i(conv_s), .rise_o(conv_rise), .fall_o(conv_fall)
  );

  cb_sequencer u_seq (
    .clk(clk), .rst(rst), .trip_i(trip_s), .rise_i(conv_rise), .fall_i(conv_fall),
    .active_o(active)
  );

  cb_pulse_shaper #(.WIDTH_W(WIDTH_W)) u_shape (
    .clk(clk), .rst(rst), .active_i(active), .width_i(short_width), .pulse_lo_o(pulse_lo)
  );

  assign switch_en = active;
  assign pulse_n   = ~pulse_lo;

  // R5
  pulse_inside_chk: assert property (@(posedge clk) disable iff (rst)
    !pulse_n |-> switch_en);

  // R5
  pulse_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(switch_en) |-> !pulse_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!switch_en && pulse_n));
endmodule

// File: tb/cb_reset_ctrl_test.sv
module cb_reset_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int PERIOD = 2 * HALF;
  localparam int WW = 8;
  localparam int IREF = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_clk = 1'b0;
  logic trip_man = 1'b0;
  logic model_on = 1'b0;
  logic acc_pos = 1'b0;
  logic [WW-1:0] short_width = '0;
  logic cmp_trip, switch_en, pulse_n;
  int vin = 0;
  int acc = 0;

  int errors = 0, checks = 0;
  int cyc = 0, ph_cnt = 0, rise_cnt = 0, fall_cnt = 0, last_rise = 0;
  int sw_count = 0, sw_rise_cyc = 0, pl_fall_cyc = 0;
  int sw_len = 0, pl_len = 0, lat = 0, rise_at_sw = 0, align_ok = 0;
  int prev_sw_rise = 0, gap_bad = 0, pl_count = 0;
  logic have_prev = 1'b0, gap_watch = 1'b0, watch_prev = 1'b0;
  logic sw_prev = 1'b0, pl_prev = 1'b1;

  assign cmp_trip = model_on ? acc_pos : trip_man;

  cb_reset_ctrl #(.WIDTH_W(WW)) uut (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .cmp_trip(cmp_trip),
    .short_width(short_width), .switch_en(switch_en), .pulse_n(pulse_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // conversion clock source and integrator model
  always @(negedge clk) begin
    if (ph_cnt == HALF - 1) begin
      ph_cnt <= 0;
      conv_clk <= ~conv_clk;
      if (!conv_clk) begin rise_cnt <= rise_cnt + 1; last_rise <= cyc; end
      else fall_cnt <= fall_cnt + 1;
    end else ph_cnt <= ph_cnt + 1;
    if (!model_on) begin
      acc = 0;
    end else begin
      acc = acc + vin - (switch_en ? IREF : 0);
    end
    acc_pos <= (acc > 0);
  end

  // port monitor
  always @(negedge clk) begin
    watch_prev <= gap_watch;
    if (gap_watch && !watch_prev) have_prev <= 1'b0;
    if (switch_en && !sw_prev) begin
      sw_count <= sw_count + 1;
      sw_rise_cyc <= cyc;
      lat <= cyc - last_rise;
      rise_at_sw <= rise_cnt;
      if (gap_watch && have_prev && (cyc - prev_sw_rise) != 2 * PERIOD) gap_bad <= gap_bad + 1;
      if (gap_watch) have_prev <= 1'b1;
      prev_sw_rise <= cyc;
    end
    if (!switch_en && sw_prev) sw_len <= cyc - sw_rise_cyc;
    if (!pulse_n && pl_prev) begin
      pl_fall_cyc <= cyc;
      pl_count <= pl_count + 1;
      align_ok <= (switch_en && !sw_prev) ? 1 : 0;
    end
    if (pulse_n && !pl_prev) pl_len <= cyc - pl_fall_cyc;
    sw_prev <= switch_en;
    pl_prev <= pulse_n;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    chk(switch_en == 1'b0, "R1 switch_en in reset", switch_en, 0);
    chk(pulse_n == 1'b1, "R1 pulse_n in reset", pulse_n, 1);
    rst = 1'b0;
    step(1);
    chk(!switch_en && pulse_n, "R1 idle after release", {switch_en, pulse_n}, 1);
  endtask

  task automatic wait_rise();
    int r;
    r = rise_cnt;
    while (rise_cnt == r) step(1);
  endtask

  task automatic wait_fall();
    int f;
    f = fall_cnt;
    while (fall_cnt == f) step(1);
  endtask

  task automatic wait_switch(input int base);
    int guard = 0;
    while (sw_count == base && guard < 10 * PERIOD) begin step(1); guard++; end
  endtask

  task automatic t_idle();
    int s0, p0;
    model_on = 1'b0; trip_man = 1'b0;
    s0 = sw_count; p0 = pl_count;
    step(10 * PERIOD);
    chk(sw_count == s0, "R2 no reset without trip", sw_count - s0, 0);
    chk(pl_count == p0, "R2 no pulse without trip", pl_count - p0, 0);
  endtask

  task automatic t_single(input bit low_phase, input int w, input int exp_pl);
    int r0, s0;
    short_width = w[WW-1:0];
    if (low_phase) wait_fall(); else wait_rise();
    step(1);
    r0 = rise_cnt; s0 = sw_count;
    trip_man = 1'b1;
    wait_switch(s0);
    trip_man = 1'b0;
    step(PERIOD + 2);
    chk(rise_at_sw == r0 + (low_phase ? 2 : 1), "R3 qualifying edge", rise_at_sw - r0,
        low_phase ? 2 : 1);
    chk(lat == 3, "R4 start latency", lat, 3);
    chk(sw_len == PERIOD, "R4 interval length", sw_len, PERIOD);
    chk(align_ok == 1, "R5 pulse aligned with switch", align_ok, 1);
    if (w == 0 || w >= PERIOD)
      chk(pl_len == exp_pl, "R7 full pulse width", pl_len, exp_pl);
    else
      chk(pl_len == exp_pl, "R6 shortened width", pl_len, exp_pl);
    s0 = sw_count;
    step(3 * PERIOD);
    chk(sw_count == s0, "R8 no re-arm after trip drop", sw_count - s0, 0);
  endtask

  task automatic t_overrange();
    int s0, b0;
    short_width = '0;
    vin = IREF + IREF / 4;
    model_on = 1'b1;
    step(4 * PERIOD);
    s0 = sw_count; b0 = gap_bad;
    gap_watch = 1'b1;
    step(40 * PERIOD);
    gap_watch = 1'b0;
    chk(gap_bad == b0, "R8 spacing two periods", gap_bad - b0, 0);
    chk((sw_count - s0) >= 19 && (sw_count - s0) <= 21, "R8 overrange rate",
        sw_count - s0, 20);
    model_on = 1'b0; trip_man = 1'b0;
    step(3 * PERIOD);
  endtask

  task automatic run_rate(input int w, output int n);
    int s0;
    short_width = w[WW-1:0];
    vin = IREF / 4;
    model_on = 1'b1;
    s0 = sw_count;
    step(64 * PERIOD);
    n = sw_count - s0;
    model_on = 1'b0;
    step(3 * PERIOD);
  endtask

  task automatic t_rate();
    int n0, n1;
    run_rate(0, n0);
    chk(n0 >= 14 && n0 <= 18, "R9 average rate", n0, 16);
    run_rate(3, n1);
    chk((n1 - n0) <= 1 && (n0 - n1) <= 1, "R9 rate with shortener", n1, n0);
  endtask

  task automatic t_midreset();
    int s0;
    s0 = sw_count;
    trip_man = 1'b1;
    wait_switch(s0);
    step(2);
    rst = 1'b1;
    step(1);
    chk(!switch_en && pulse_n, "R1 mid-interval reset", {switch_en, pulse_n}, 1);
    trip_man = 1'b0;
    step(2);
    rst = 1'b0;
    step(2 * PERIOD);
    chk(!switch_en && pulse_n, "R1 idle after mid reset", {switch_en, pulse_n}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    step(1);
    do_reset();
    t_idle();
    t_single(1'b0, 0, PERIOD);
    t_single(1'b1, 0, PERIOD);
    t_single(1'b0, 3, 3);
    t_single(1'b0, 1, 1);
    t_single(1'b1, PERIOD, PERIOD);
    t_single(1'b0, 20, PERIOD);
    t_overrange();
    t_rate();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule